// File: doc/BRIEF.md
# Dual Countdown Timer Unit

This block holds two independent countdown timers and a free-running time counter behind a small byte-addressed register interface with a combinational read path. Each timer owns a divisor register that software writes ahead of time, a readable live count and a control register. A control write picks one of three operations (load the count, hold it, or let it run) and a tick-rate code that chooses which of four external single-cycle enable strobes advances the counter.

A running timer steps down by one on each selected strobe. When a strobe arrives while its count is 0 or 1, the timer expires: it reloads from the limit captured at the last control write and sets its bit in a shared raw interrupt status. The raw status is cleared by writing ones to an acknowledge offset, is gated by a mask register, and any set masked bit drives a single level interrupt output. The rate strobes come from elsewhere in the chip. This block only selects among them.

Top module: `dual_countdown_timer`

## Requirements
- R1: While reset is asserted and after its release, both counts read 0, both timers are stopped, the raw status (0x50) and mask (0x48) read 0, the time counter reads 0 during reset, and `irq_o` is low.
- R2: A control write (timer0 at 0x08, timer1 at 0x18) decodes bits [1:0] as the operation. 0 copies the divisor into the count and stops the timer. 1 stops the timer and keeps the count. 2 starts the timer and keeps the count. 3 is ignored entirely: operation, rate and limit stay unchanged.
- R3: A divisor write (timer0 at 0x00, timer1 at 0x10) changes neither the count nor the reload limit. Every accepted control write copies the current divisor into the reload limit and does not alter the count unless the operation is 0.
- R4: Control bits [4:2] hold the rate code. Codes 4, 5, 6 and 7 select strobe `tick_i[0]`, `[1]`, `[2]` and `[3]`. A running timer decrements by one only on its selected strobe, and it never counts with codes 0 to 3.
- R5: When a selected strobe reaches a running timer whose count is 0 or 1, the timer reloads the limit and keeps running. Timer0 sets raw bit 0 and timer1 sets raw bit 1. A divisor of D therefore expires every D strobes for D ≥ 1.
- R6: A write to 0x4C clears every raw bit that is 1 in the written data. An expiry in the same cycle wins over the clear. The written value is not stored.
- R7: The mask register at 0x48 keeps data bits [1:0] and reads them back. Offset 0x54 reads raw AND mask. `irq_o` is high exactly when that product is nonzero, and it follows mask and acknowledge writes on the next cycle.
- R8: The time counter at 0x38 increments by one every clock cycle and wraps.
- R9: Reads of the divisor, control and acknowledge offsets and of unmapped offsets return 0. Writes to read-only offsets (counts, 0x38, 0x50, 0x54) and to unmapped offsets change no state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| bus_addr_i | input | 8 | Byte offset of the register access |
| bus_we_i | input | 1 | Write strobe for one cycle |
| bus_wdata_i | input | 32 | Write data |
| bus_rdata_o | output | 32 | Read data for `bus_addr_i`, combinational |
| tick_i | input | 4 | Single-cycle rate enable strobes, one per rate code 4 to 7 |
| irq_o | output | 1 | Level interrupt, high while any masked status bit is set |

## Verification
The assertions assume that every input is synchronous to `clk`, that a write lasts exactly one cycle with a stable address, and that each tick strobe is a single-cycle pulse. The checks on count steps also assume that only the strobe of the selected code matters. The bench changes all inputs on the falling edge and holds each write or strobe for one cycle. It sweeps every rate code against divisors 1 to 5 and drives an acknowledge and an expiry in the same cycle to exercise the priority rule.

// File: rtl/tmr_pkg.sv
package tmr_pkg;

  localparam int unsigned DATA_W     = 32;
  localparam int unsigned ADDR_W     = 8;

  // Per-timer offsets relative to the timer base; bases are spaced by the stride
  localparam int unsigned TMR_STRIDE = 16;
  localparam int unsigned OFS_DIV    = 0;
  localparam int unsigned OFS_CNT    = 4;
  localparam int unsigned OFS_CTL    = 8;

  // Shared offsets
  localparam int unsigned OFS_TIME   = 56;   // 0x38
  localparam int unsigned OFS_MASK   = 72;   // 0x48
  localparam int unsigned OFS_ACK    = 76;   // 0x4C
  localparam int unsigned OFS_RAW    = 80;   // 0x50
  localparam int unsigned OFS_MSKST  = 84;   // 0x54

  typedef enum logic [1:0] {
    OP_LOAD = 2'd0,
    OP_HOLD = 2'd1,
    OP_RUN  = 2'd2,
    OP_BAD  = 2'd3
  } tmr_op_e;

endpackage

// File: rtl/tmr_channel.sv
module tmr_channel
  import tmr_pkg::*;
#(
  parameter int unsigned CNT_W      = 32,
  parameter int unsigned NUM_SRC    = 4,
  parameter int unsigned RATE_W     = 3,
  parameter int unsigned FIRST_CODE = 4
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               div_we,
  input  logic               ctl_we,
  input  logic [CNT_W-1:0]   wdata,
  input  tmr_op_e            ctl_op,
  input  logic [RATE_W-1:0]  ctl_rate,
  input  logic [NUM_SRC-1:0] tick_i,
  output logic [CNT_W-1:0]   count_o,
  output logic               hit_o
);

  logic [CNT_W-1:0]  div_q, div_d;
  logic [CNT_W-1:0]  lim_q, lim_d;
  logic [CNT_W-1:0]  cnt_q, cnt_d;
  logic [RATE_W-1:0] rate_q, rate_d;
  logic              run_q, run_d;
  logic              sel;
  logic              ctl_ok;

  // Strobe selected by the rate code; codes below FIRST_CODE select nothing
  always_comb begin
    sel = 1'b0;
    for (int i = 0; i < NUM_SRC; i++) begin
      if (rate_q == RATE_W'(FIRST_CODE + i)) sel = tick_i[i];
    end
  end

  assign ctl_ok = ctl_we && (ctl_op != OP_BAD);

  always_comb begin
    div_d  = div_q;
    lim_d  = lim_q;
    cnt_d  = cnt_q;
    rate_d = rate_q;
    run_d  = run_q;
    hit_o  = 1'b0;
    if (div_we) div_d = wdata;
    if (ctl_ok) begin
      lim_d  = div_q;
      rate_d = ctl_rate;
      unique case (ctl_op)
        OP_LOAD: begin
          cnt_d = div_q;
          run_d = 1'b0;
        end
        OP_HOLD: run_d = 1'b0;
        OP_RUN:  run_d = 1'b1;
        default: run_d = run_q;
      endcase
    end else if (run_q && sel) begin
      if (cnt_q <= CNT_W'(1)) begin
        cnt_d = lim_q;
        hit_o = 1'b1;
      end else begin
        cnt_d = cnt_q - CNT_W'(1);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      div_q  <= '0;
      lim_q  <= '0;
      cnt_q  <= '0;
      rate_q <= '0;
      run_q  <= 1'b0;
    end else begin
      div_q  <= div_d;
      lim_q  <= lim_d;
      cnt_q  <= cnt_d;
      rate_q <= rate_d;
      run_q  <= run_d;
    end
  end

  assign count_o = cnt_q;

  // R2
  stopped_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!run_q && !ctl_we) |=> $stable(cnt_q));

  // R2
  bad_op_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ctl_we && ctl_op == OP_BAD) |=> ($stable(run_q) && $stable(rate_q) && $stable(lim_q)));

  // R4
  unselected_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (run_q && !sel && !ctl_we) |=> $stable(cnt_q));

  // R5
  reload_chk: assert property (@(posedge clk) disable iff (!rst_n)
    hit_o |=> (cnt_q == $past(lim_q)) && run_q);

endmodule

// File: rtl/tmr_irq.sv
module tmr_irq #(
  parameter int unsigned NUM_TMR = 2
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NUM_TMR-1:0] hit_i,
  input  logic               mask_we,
  input  logic               ack_we,
  input  logic [NUM_TMR-1:0] wbits,
  output logic [NUM_TMR-1:0] raw_o,
  output logic [NUM_TMR-1:0] mask_o,
  output logic               irq_o
);

  logic [NUM_TMR-1:0] raw_q, raw_d;
  logic [NUM_TMR-1:0] mask_q, mask_d;
  logic [NUM_TMR-1:0] clr;

  always_comb begin
    clr    = ack_we ? wbits : '0;
    raw_d  = (raw_q & ~clr) | hit_i;
    mask_d = mask_we ? wbits : mask_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      raw_q  <= '0;
      mask_q <= '0;
    end else begin
      raw_q  <= raw_d;
      mask_q <= mask_d;
    end
  end

  assign raw_o  = raw_q;
  assign mask_o = mask_q;
  assign irq_o  = |(raw_q & mask_q);

  // R5
  hit_sets_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (|hit_i) |=> ((raw_q & $past(hit_i)) == $past(hit_i)));

  // R6
  ack_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ack_we |=> ((raw_q & $past(wbits & ~hit_i)) == '0));

  // R7
  masked_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mask_q == '0) |-> !irq_o);

endmodule

// File: rtl/dual_countdown_timer.sv
module dual_countdown_timer
  import tmr_pkg::*;
#(
  parameter int unsigned CNT_W   = 32,
  parameter int unsigned NUM_SRC = 4,
  parameter int unsigned TIME_W  = 32
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [ADDR_W-1:0]  bus_addr_i,
  input  logic               bus_we_i,
  input  logic [DATA_W-1:0]  bus_wdata_i,
  output logic [DATA_W-1:0]  bus_rdata_o,
  input  logic [NUM_SRC-1:0] tick_i,
  output logic               irq_o
);

  localparam int unsigned NUM_TMR    = 2;
  localparam int unsigned RATE_W     = 3;
  localparam int unsigned FIRST_CODE = 4;

  // Reset: asserted asynchronously, released after two clock edges
  logic [1:0] rs_q;
  logic       rst_n_s;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rs_q <= '0;
    else        rs_q <= {rs_q[0], 1'b1};
  end
  assign rst_n_s = rs_q[1];

  tmr_op_e           ctl_op;
  logic [RATE_W-1:0] ctl_rate;
  assign ctl_op   = tmr_op_e'(bus_wdata_i[1:0]);
  assign ctl_rate = bus_wdata_i[RATE_W+1:2];

  logic [CNT_W-1:0]   cnt [NUM_TMR];
  logic [NUM_TMR-1:0] hit;
  logic [NUM_TMR-1:0] div_we, ctl_we;

  for (genvar g = 0; g < NUM_TMR; g++) begin : g_tmr
    localparam int unsigned BASE = g * TMR_STRIDE;

    assign div_we[g] = bus_we_i && (bus_addr_i == ADDR_W'(BASE + OFS_DIV));
    assign ctl_we[g] = bus_we_i && (bus_addr_i == ADDR_W'(BASE + OFS_CTL));

    tmr_channel #(
      .CNT_W      (CNT_W),
      .NUM_SRC    (NUM_SRC),
      .RATE_W     (RATE_W),
      .FIRST_CODE (FIRST_CODE)
    ) i_chan (
      .clk      (clk),
      .rst_n    (rst_n_s),
      .div_we   (div_we[g]),
      .ctl_we   (ctl_we[g]),
      .wdata    (bus_wdata_i[CNT_W-1:0]),
      .ctl_op   (ctl_op),
      .ctl_rate (ctl_rate),
      .tick_i   (tick_i),
      .count_o  (cnt[g]),
      .hit_o    (hit[g])
    );
  end

  // Interrupt status, mask and output
  logic               mask_we, ack_we;
  logic [NUM_TMR-1:0] raw, mask;

  assign mask_we = bus_we_i && (bus_addr_i == ADDR_W'(OFS_MASK));
  assign ack_we  = bus_we_i && (bus_addr_i == ADDR_W'(OFS_ACK));

  tmr_irq #(
    .NUM_TMR (NUM_TMR)
  ) i_irq (
    .clk     (clk),
    .rst_n   (rst_n_s),
    .hit_i   (hit),
    .mask_we (mask_we),
    .ack_we  (ack_we),
    .wbits   (bus_wdata_i[NUM_TMR-1:0]),
    .raw_o   (raw),
    .mask_o  (mask),
    .irq_o   (irq_o)
  );

  // Free-running time counter
  logic [TIME_W-1:0] time_q, time_d;

  assign time_d = time_q + TIME_W'(1);

  always_ff @(posedge clk or negedge rst_n_s) begin
    if (!rst_n_s) time_q <= '0;
    else          time_q <= time_d;
  end

  // Read path; write-only and unmapped offsets return zero
  always_comb begin
    bus_rdata_o = '0;
    if (bus_addr_i == ADDR_W'(OFS_TIME))  bus_rdata_o = DATA_W'(time_q);
    if (bus_addr_i == ADDR_W'(OFS_MASK))  bus_rdata_o = DATA_W'(mask);
    if (bus_addr_i == ADDR_W'(OFS_RAW))   bus_rdata_o = DATA_W'(raw);
    if (bus_addr_i == ADDR_W'(OFS_MSKST)) bus_rdata_o = DATA_W'(raw & mask);
    for (int i = 0; i < NUM_TMR; i++) begin
      if (bus_addr_i == ADDR_W'(i * TMR_STRIDE + OFS_CNT)) bus_rdata_o = DATA_W'(cnt[i]);
    end
  end

  // R8
  time_step_chk: assert property (@(posedge clk) disable iff (!rst_n_s)
    (time_q != '0) |-> (time_q == $past(time_q) + TIME_W'(1)));

  // R9
  no_stray_write_chk: assert property (@(posedge clk) disable iff (!rst_n_s)
    (bus_we_i && !mask_we && !ack_we && (div_we == '0) && (ctl_we == '0))
      |=> ($stable(mask) && $stable(raw & ~$past(hit))));

endmodule

// File: tb/test_dual_countdown_timer.sv
module test_dual_countdown_timer;

  logic        clk = 1'b0;
  logic        rst_n;
  logic [7:0]  bus_addr_i;
  logic        bus_we_i;
  logic [31:0] bus_wdata_i;
  logic [31:0] bus_rdata_o;
  logic [3:0]  tick_i;
  logic        irq_o;

  int checks = 0;
  int errors = 0;
  bit done   = 1'b0;

  always #2 clk = ~clk;

  dual_countdown_timer i_dual_countdown_timer (
    .clk         (clk),
    .rst_n       (rst_n),
    .bus_addr_i  (bus_addr_i),
    .bus_we_i    (bus_we_i),
    .bus_wdata_i (bus_wdata_i),
    .bus_rdata_o (bus_rdata_o),
    .tick_i      (tick_i),
    .irq_o       (irq_o)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    bus_addr_i = a;
    #1;
    d = bus_rdata_o;
  endtask

  task automatic chkrd(input string req, input logic [7:0] a, input logic [31:0] exp);
    logic [31:0] d;
    rd(a, d);
    chk(req, d, exp);
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_addr_i  = a;
    bus_wdata_i = d;
    bus_we_i    = 1'b1;
    @(negedge clk);
    bus_we_i    = 1'b0;
  endtask

  task automatic tick(input logic [3:0] m);
    @(negedge clk);
    tick_i = m;
    @(negedge clk);
    tick_i = '0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual running expected finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [31:0] t0, t1;
    rst_n       = 1'b0;
    bus_addr_i  = '0;
    bus_we_i    = 1'b0;
    bus_wdata_i = '0;
    tick_i      = '0;
    repeat (3) @(negedge clk);

    // R1: state held in reset
    chkrd("R1 count0", 8'h04, 0);
    chkrd("R1 count1", 8'h14, 0);
    chkrd("R1 raw", 8'h50, 0);
    chkrd("R1 mask", 8'h48, 0);
    chkrd("R1 time", 8'h38, 0);
    chk("R1 irq", irq_o, 0);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);
    chkrd("R1 raw after release", 8'h50, 0);
    tick(4'hF);
    chkrd("R1 stopped count0", 8'h04, 0);
    chkrd("R1 stopped count1", 8'h14, 0);

    // R4/R5 sweep on timer1: every rate code, divisors 1..5
    for (int r = 4; r < 8; r++) begin
      for (int d = 1; d < 6; d++) begin
        logic [3:0] own, other;
        own   = 4'(1 << (r - 4));
        other = 4'(1 << ((r - 3) % 4));
        wr(8'h10, d);
        wr(8'h18, (r << 2) | 0);
        chkrd("R2 load copies divisor", 8'h14, d);
        wr(8'h18, (r << 2) | 2);
        chkrd("R3 run keeps count", 8'h14, d);
        tick(other);
        chkrd("R4 other strobe ignored", 8'h14, d);
        for (int k = 1; k <= d; k++) begin
          tick(own);
          chkrd("R5 timer1 count", 8'h14, (k < d) ? (d - k) : d);
          chkrd("R5 timer1 raw bit1", 8'h50, (k < d) ? 0 : 2);
        end
        chk("R7 irq masked off", irq_o, 0);
        wr(8'h4C, 2);
        chkrd("R6 ack bit1", 8'h50, 0);
      end
    end
    wr(8'h18, (7 << 2) | 1);   // hold timer1 at 5

    // R3 on timer0: divisor alone does not change reload
    wr(8'h00, 3);
    wr(8'h08, 32'h10);
    chkrd("R2 load timer0", 8'h04, 3);
    wr(8'h08, 32'h12);
    tick(4'h1);
    chkrd("R4 timer0 step", 8'h04, 2);
    wr(8'h00, 9);
    chkrd("R3 divisor write keeps count", 8'h04, 2);
    tick(4'h1);
    tick(4'h1);
    chkrd("R3 reload uses old limit", 8'h04, 3);
    chkrd("R5 timer0 raw bit0", 8'h50, 1);
    wr(8'h08, 32'h12);
    chkrd("R3 control write keeps count", 8'h04, 3);
    wr(8'h4C, 1);
    chkrd("R6 ack bit0", 8'h50, 0);
    chkrd("R6 ack not stored", 8'h4C, 0);

    // R2: operation code 3 ignored
    wr(8'h08, 32'h03);
    tick(4'h1);
    chkrd("R2 illegal op ignored", 8'h04, 2);
    // R2: hold
    wr(8'h08, 32'h11);
    tick(4'h1);
    chkrd("R2 hold stops", 8'h04, 2);
    // R4: codes 0..3 never count
    for (int c = 0; c < 4; c++) begin
      wr(8'h08, (c << 2) | 2);
      tick(4'hF);
      chkrd("R4 disabled rate code", 8'h04, 2);
    end

    // R6/R7: mask, irq, acknowledge colliding with expiry
    wr(8'h08, 32'h12);
    wr(8'h48, 32'hFFFF_FFFF);
    chkrd("R7 mask readback", 8'h48, 3);
    tick(4'h1);
    chkrd("R4 count to one", 8'h04, 1);
    @(negedge clk);
    tick_i      = 4'h1;
    bus_addr_i  = 8'h4C;
    bus_wdata_i = 32'h1;
    bus_we_i    = 1'b1;
    @(negedge clk);
    tick_i   = '0;
    bus_we_i = 1'b0;
    chkrd("R6 expiry wins over ack", 8'h50, 1);
    chkrd("R5 reload new limit", 8'h04, 9);
    chkrd("R7 masked status", 8'h54, 1);
    #1 chk("R7 irq high", irq_o, 1);
    wr(8'h48, 2);
    chkrd("R7 masked status off", 8'h54, 0);
    #1 chk("R7 irq low by mask", irq_o, 0);
    chkrd("R7 raw kept", 8'h50, 1);
    wr(8'h48, 3);
    #1 chk("R7 irq high again", irq_o, 1);
    wr(8'h4C, 32'hFFFF_FFFF);
    chkrd("R6 ack all", 8'h50, 0);
    #1 chk("R7 irq low by ack", irq_o, 0);

    // R9: read-only and unmapped offsets
    wr(8'h20, 32'hFFFF_FFFF);
    wr(8'h50, 32'hFFFF_FFFF);
    wr(8'h54, 32'hFFFF_FFFF);
    wr(8'h04, 32'h0000_0055);
    wr(8'h14, 32'h0000_0055);
    wr(8'h5C, 32'hFFFF_FFFF);
    chkrd("R9 raw untouched", 8'h50, 0);
    chkrd("R9 mask untouched", 8'h48, 3);
    chkrd("R9 count0 untouched", 8'h04, 9);
    chkrd("R9 count1 untouched", 8'h14, 5);
    chkrd("R9 read div0", 8'h00, 0);
    chkrd("R9 read ctl0", 8'h08, 0);
    chkrd("R9 read div1", 8'h10, 0);
    chkrd("R9 read ctl1", 8'h18, 0);
    chkrd("R9 read ack", 8'h4C, 0);
    chkrd("R9 read unmapped 0x20", 8'h20, 0);
    chkrd("R9 read unmapped 0x3C", 8'h3C, 0);
    chkrd("R9 read unmapped 0x58", 8'h58, 0);

    // R8: time counter steps once per clock
    @(negedge clk);
    rd(8'h38, t0);
    repeat (37) @(negedge clk);
    rd(8'h38, t1);
    chk("R8 time delta", t1 - t0, 37);

    // R1: reset in the middle of activity
    wr(8'h08, 32'h12);
    @(negedge clk);
    rst_n = 1'b0;
    chkrd("R1 mid reset count0", 8'h04, 0);
    chkrd("R1 mid reset mask", 8'h48, 0);
    chk("R1 mid reset irq", irq_o, 0);

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule